// File: doc/BRIEF.md
# Edge-Interrupt GPIO Register Block

This block is an eight-pin general purpose I/O controller behind a byte-wide register port. The lower four pins are driven outputs and the upper four pins are sampled inputs. Software reads and writes four registers: pin direction, pin data, per-input trigger selection and interrupt status. A single level interrupt line tells the host that an input event is waiting.

Every input is resynchronised to the block clock and then compared with its previous sample. Each input has two independent pending flags, one for rising transitions and one for falling transitions. Both flags latch whatever the trigger selection is. A 2-bit trigger field per input decides which of the two flags shows in the status register and so which can raise the interrupt. Software acknowledges an event by writing ones to the status register. That clears both flags of each addressed input, so a flag that was latched while hidden cannot appear later as a stale event.

Top module: `egpio_regblock`

## Requirements
- R1: After reset the direction register reads 0x0F, the trigger register 0x00, the status register 0x00, the data output latch holds 0x00, `irq` is low, `pin_oe` is 0x0F and `pin_out` is 0x00.
- R2: The direction register sits at offset 0 and reads back what was written. A 1 bit means output. `pin_oe[i]` equals direction bit i for pins 0 to 3, and `pin_oe[7:4]` is always 0.
- R3: A write to offset 1 stores bits [3:0] as output values. `pin_out[i]` for pins 0 to 3 equals the stored bit when direction bit i is 1 and is 0 otherwise. `pin_out[7:4]` is always 0.
- R4: A read of offset 1 returns the levels of all eight `pin_in` bits after a two-flop synchroniser. It never returns the value last written.
- R5: A 0-to-1 transition on input pin i+4 sets the rising flag of input i three clock edges after the pin changes. Status bit i shows that flag when bit 2i+1 of the trigger register (offset 3) is 1.
- R6: A 1-to-0 transition on input pin i+4 sets the falling flag of input i. Status bit i shows that flag when bit 2i of the trigger register is 1.
- R7: With a trigger field of 00 the flags still latch, but status bit i and `irq` stay 0. Enabling the field later makes the latched flag visible.
- R8: `irq` is high exactly when at least one status bit reads 1.
- R9: Writing a 1 to status bit i (offset 4) clears both flags of input i, whatever the trigger field is. Bits written as 0 keep their flags.
- R10: If an edge is detected on the same clock edge as the clearing write, the flag for that edge stays set.
- R11: Status bits [7:4] read 0. Offsets 2, 5, 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, taken on the rising clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 8 | Pad levels of all eight pins |
| pin_out | output | 8 | Output drive values |
| pin_oe | output | 8 | Output driver enables |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that a detected edge always leaves its flag set on the next cycle, even if a clear arrives on the same edge. They also check that a clear with no competing edge empties both flags, that no flag drops without a clear, that the input pins never get an output enable, that no disabled pin is driven, and that `irq` never rises with both flag sets empty. Only the bench scenarios can show the register-level behaviour. That covers reset values, decode of each offset, the three-edge latency from pin to status, hidden flags showing up after the trigger field is enabled, and the read path returning pad levels rather than written data. A seeded random sequence of pin toggles, trigger changes and partial clears is checked against a flag model kept in the bench.

// File: rtl/egpio_pkg.sv
package egpio_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_TRIG = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;

  // Visible status for one input: field[1] gates rising, field[0] gates falling
  function automatic logic stat_bit(input logic [1:0] field, input logic rise_f,
                                    input logic fall_f);
    return (field[1] & rise_f) | (field[0] & fall_f);
  endfunction

  // Next value of a pending flag: clear loses against a fresh edge
  function automatic logic next_flag(input logic cur, input logic clr, input logic ev);
    return (cur & ~clr) | ev;
  endfunction
endpackage

// File: rtl/egpio_sync.sv
module egpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/egpio_edge_cell.sv
module egpio_edge_cell
  import egpio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic rise_ev,
  output logic fall_ev,
  output logic rise_pend,
  output logic fall_pend
);
  logic prev;

  assign rise_ev = lvl & ~prev;
  assign fall_ev = ~lvl & prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev      <= 1'b0;
      rise_pend <= 1'b0;
      fall_pend <= 1'b0;
    end else begin
      prev      <= lvl;
      rise_pend <= next_flag(rise_pend, clr, rise_ev);
      fall_pend <= next_flag(fall_pend, clr, fall_ev);
    end
  end
endmodule

// File: rtl/egpio_regblock.sv
module egpio_regblock
  import egpio_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned NOUT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int unsigned NIN = NPINS - NOUT;
  localparam int unsigned TW  = 2 * NIN;
  localparam logic [NPINS-1:0] DIR_RST = {{NIN{1'b0}}, {NOUT{1'b1}}};

  logic [NPINS-1:0] dir_q;
  logic [NOUT-1:0]  dout_q;
  logic [TW-1:0]    trig_q;
  logic [NPINS-1:0] pin_sync;
  logic [NIN-1:0]   clr_mask;
  logic [NIN-1:0]   rise_ev, fall_ev, rise_pend, fall_pend;
  logic [NIN-1:0]   stat_vis;
  logic [NPINS-1:0] stat_rd;

  egpio_sync #(.W(NPINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign clr_mask = (wr_en && addr == OFF_STAT) ? wr_data[NIN-1:0] : '0;

  for (genvar i = 0; i < NIN; i++) begin : g_in
    egpio_edge_cell cell_i (
      .clk(clk), .rst_n(rst_n), .lvl(pin_sync[NOUT+i]), .clr(clr_mask[i]),
      .rise_ev(rise_ev[i]), .fall_ev(fall_ev[i]),
      .rise_pend(rise_pend[i]), .fall_pend(fall_pend[i])
    );
    assign stat_vis[i] = stat_bit(trig_q[2*i+1 -: 2], rise_pend[i], fall_pend[i]);
  end

  assign stat_rd = {{NOUT{1'b0}}, stat_vis};
  assign irq     = |stat_vis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= DIR_RST;
      dout_q <= '0;
      trig_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_DIR:  dir_q  <= wr_data;
        OFF_DATA: dout_q <= wr_data[NOUT-1:0];
        OFF_TRIG: trig_q <= wr_data[TW-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFF_DIR:  rd_data = dir_q;
      OFF_DATA: rd_data = pin_sync;
      OFF_TRIG: rd_data = NPINS'(trig_q);
      OFF_STAT: rd_data = stat_rd;
      default:  rd_data = '0;
    endcase
  end

  assign pin_oe  = {{NIN{1'b0}}, dir_q[NOUT-1:0]};
  assign pin_out = {{NIN{1'b0}}, dout_q & dir_q[NOUT-1:0]};
endmodule

// File: rtl/egpio_regblock_chk.sv
module egpio_regblock_chk #(
  parameter int unsigned NPINS = 8,
  parameter int unsigned NOUT  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  irq,
  input logic [NPINS-1:0]      pin_out,
  input logic [NPINS-1:0]      pin_oe,
  input logic [NPINS-NOUT-1:0] rise_ev,
  input logic [NPINS-NOUT-1:0] fall_ev,
  input logic [NPINS-NOUT-1:0] rise_pend,
  input logic [NPINS-NOUT-1:0] fall_pend,
  input logic [NPINS-NOUT-1:0] clr_mask
);
  AST_INPUT_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[NPINS-1:NOUT] == '0); // R2
  AST_OUT_ONLY_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R3
  AST_RISE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_ev) |=> ((rise_pend & $past(rise_ev)) == $past(rise_ev))); // R5
  AST_FALL_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall_ev) |=> ((fall_pend & $past(fall_ev)) == $past(fall_ev))); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((rise_pend | fall_pend) != '0)); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((rise_pend & $past(clr_mask & ~rise_ev)) == '0 &&
                     (fall_pend & $past(clr_mask & ~fall_ev)) == '0)); // R9
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_pend | fall_pend)) |=>
      (($past(rise_pend) & ~$past(clr_mask) & ~rise_pend) == '0 &&
       ($past(fall_pend) & ~$past(clr_mask) & ~fall_pend) == '0)); // R9
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & rise_ev)) |=> ((rise_pend & $past(clr_mask & rise_ev)) != '0)); // R10
endmodule

bind egpio_regblock egpio_regblock_chk #(.NPINS(NPINS), .NOUT(NOUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pin_out(pin_out), .pin_oe(pin_oe),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .rise_pend(rise_pend),
  .fall_pend(fall_pend), .clr_mask(clr_mask)
);

// File: tb/egpio_regblock_tb.sv
`timescale 1ns/1ps
module egpio_regblock_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic       irq;

  int total = 0;
  int bad = 0;

  // bench model of the flags
  logic [3:0] m_rise = '0, m_fall = '0, m_lvl = '0;
  logic [7:0] m_trig = '0;

  always #2 clk = ~clk;

  egpio_regblock dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [7:0] exp_stat(input logic [7:0] trig, input logic [3:0] r,
                                          input logic [3:0] f);
    logic [7:0] s = '0;
    for (int k = 0; k < 4; k++)
      if ((trig[2*k+1] && r[k]) || (trig[2*k] && f[k])) s[k] = 1'b1;
    return s;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (a == 3'd3) m_trig = d;
    if (a == 3'd4) begin m_rise &= ~d[3:0]; m_fall &= ~d[3:0]; end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; #0.5; v = rd_data;
  endtask

  // change input pins and wait until the flags are visible
  task automatic set_inputs(input logic [3:0] v);
    pin_in[7:4] = v;
    m_rise |= v & ~m_lvl;
    m_fall |= ~v & m_lvl;
    m_lvl = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_stat(input string req);
    logic [7:0] v;
    rd(3'd4, v);
    check(req, v, exp_stat(m_trig, m_rise, m_fall));
    check({req, "/R8 irq"}, {7'd0, irq}, {7'd0, |exp_stat(m_trig, m_rise, m_fall)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd0, v); check("R1 dir", v, 8'h0F);
    rd(3'd3, v); check("R1 trig", v, 8'h00);
    rd(3'd4, v); check("R1 stat", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 oe", pin_oe, 8'h0F);
    check("R1 out", pin_out, 8'h00);

    // R2 direction register and enables
    wr(3'd0, 8'h35);
    rd(3'd0, v); check("R2 dir readback", v, 8'h35);
    check("R2 oe", pin_oe, 8'h05);

    // R3 output gating by direction
    wr(3'd1, 8'hFF);
    check("R3 gated out", pin_out, 8'h05);
    wr(3'd0, 8'h0F);
    check("R3 full out", pin_out, 8'h0F);
    wr(3'd1, 8'h09);
    check("R3 new value", pin_out, 8'h09);

    // R4 data read returns synchronised pin levels
    pin_in[3:0] = 4'h3;
    set_inputs(4'hA);
    rd(3'd1, v); check("R4 pin levels", v, 8'hA3);
    wr(3'd4, 8'h0F);
    check_stat("R9 clear all");

    // R11 unused offsets and upper status bits
    rd(3'd2, v); check("R11 off2", v, 8'h00);
    rd(3'd6, v); check("R11 off6", v, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd0, v); check("R11 dir untouched", v, 8'h0F);
    rd(3'd3, v); check("R11 trig untouched", v, 8'h00);
    check("R11 out untouched", pin_out, 8'h09);

    // R7 hidden flag then revealed
    set_inputs(4'hB);              // rise on input 0
    rd(3'd4, v); check("R7 hidden stat", v, 8'h00);
    check("R7 hidden irq", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h02);
    rd(3'd4, v); check("R7 revealed", v, 8'h01);
    check("R8 irq high", {7'd0, irq}, 8'h01);

    // R5 rising on input 2, R6 falling on input 1
    wr(3'd4, 8'h0F);
    wr(3'd3, 8'h24);               // input1 falling, input2 rising
    set_inputs(4'hF);              // rise on input 2
    rd(3'd4, v); check("R5 rise input2", v, 8'h04);
    set_inputs(4'hD);              // fall on input 1
    rd(3'd4, v); check("R6 fall input1", v, 8'h06);
    rd(3'd4, v); check("R11 upper stat zero", v & 8'hF0, 8'h00);

    // R9 clear removes hidden flag too; zero bits keep flags
    wr(3'd3, 8'h00);
    set_inputs(4'h9);              // fall on input 2 (rise also latched earlier)
    wr(3'd4, 8'h04);
    wr(3'd3, 8'h30);
    rd(3'd4, v); check("R9 both cleared", v, 8'h00);
    wr(3'd3, 8'h04);
    rd(3'd4, v); check("R9 untouched bit kept", v, 8'h02);

    // R10 edge on the clearing edge wins
    wr(3'd4, 8'h0F);
    wr(3'd3, 8'h02);
    pin_in[4] = 1'b0; m_lvl[0] = 1'b0; m_fall[0] = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    pin_in[4] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    addr = 3'd4; wr_data = 8'h0F; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    m_rise = 4'h1; m_fall = '0; m_lvl[0] = 1'b1;
    rd(3'd4, v); check("R10 edge survives clear", v, 8'h01);

    // random mix against the model, R5/R6/R9
    for (int it = 0; it < 80; it++) begin
      case ($urandom % 3)
        0: set_inputs(4'($urandom));
        1: wr(3'd3, 8'($urandom));
        default: wr(3'd4, 8'($urandom));
      endcase
      check_stat("R5/R6/R9 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule